// File: doc/BRIEF.md
# Supply Fail Access Gate

This block supervises host access to a battery-backed memory and timekeeper. It receives two supply comparator flags from the analog front end: one that says the supply is above the power-fail threshold and one that says the supply is above the battery level. Both flags are asynchronous. Each passes through a synchronizer and a confirmation filter, so a flag takes effect only after it has held the same value for a set number of samples. The block also takes two static strap inputs. One chooses the supply variant, 5 V or 3.3 V. The other tells the 3.3 V variant which of its two thresholds is the lower one.

From the filtered flags the block produces three things. The first is an access grant that gates every host read and write to memory and clock registers. The second is a battery-select output that tells the power switch to run the device from the backup cell. The third is a one-time battery-connect latch. The cell stays isolated until the first time the supply is seen valid, and after that backup operation is enabled. Ordinary reset does not clear this latch. Only a dedicated factory-reset input clears it.

Top module: `sfg_supply_gate`

## Requirements
- R1: While reset is asserted and after it is released, both filtered flags read as failed until the raw flags have been confirmed. So `acc_grant` and `wr_grant` stay 0 even when `acc_req` is 1.
- R2: While the confirmed power-fail flag is valid, `acc_grant` equals `acc_req` and `wr_grant` equals `acc_req & acc_wr`, combinationally, in the same cycle.
- R3: When the confirmed power-fail flag drops, `acc_grant` and `wr_grant` fall in that same cycle even though the request and write are still held, so a write in progress is cut off.
- R4: A change on a raw flag held steady takes effect after exactly SYNC_STAGES + CONFIRM rising clock edges. One edge earlier, the old value still applies.
- R5: A raw flag pulse shorter than CONFIRM cycles has no effect on `acc_grant` or `bat_sel`.
- R6: With `low_volt` = 0 (5 V variant), `bat_sel` is 1 exactly when the latch is armed and the confirmed battery-level flag is 0. The power-fail flag has no influence on it.
- R7: With `low_volt` = 1 and `pf_under_bat` = 1, `bat_sel` is 1 exactly when the latch is armed and the confirmed power-fail flag is 0. The battery-level flag has no influence on it.
- R8: With `low_volt` = 1 and `pf_under_bat` = 0, `bat_sel` follows the battery-level flag as in R6. Strap changes act combinationally.
- R9: While `bat_armed` is 0, `bat_sel` is 0 whatever the flags.
- R10: `bat_armed` is set one edge after the confirmed power-fail flag first reads valid. It then stays set through later supply loss and through ordinary reset.
- R11: Asserting `factory_rst_n` low clears `bat_armed` at once. The latch stays clear until the supply is again confirmed valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Ordinary reset, active low, asserted asynchronously and released synchronously |
| factory_rst_n | input | 1 | Factory reset of the battery-connect latch, active low |
| pf_ok_raw | input | 1 | Asynchronous comparator flag: supply above the power-fail threshold |
| bat_ok_raw | input | 1 | Asynchronous comparator flag: supply above the battery level |
| low_volt | input | 1 | Variant strap: 0 selects 5 V behaviour, 1 selects 3.3 V behaviour |
| pf_under_bat | input | 1 | Strap for the 3.3 V variant: 1 when the power-fail threshold lies below the battery voltage |
| acc_req | input | 1 | Host access request to memory or clock registers |
| acc_wr | input | 1 | Host access is a write |
| acc_grant | output | 1 | Access allowed |
| wr_grant | output | 1 | Write strobe allowed |
| bat_sel | output | 1 | Run the device from the backup cell |
| bat_armed | output | 1 | Backup cell connected (one-time latch) |

## Verification
The bench builds the block with its default SYNC_STAGES = 2 and CONFIRM = 2. That gives a four-edge flag latency, so the test can check the last edge at which the old value still holds and the first edge that shows the new one. With a confirmation window of two, a single-cycle glitch is the longest pulse that must be filtered out, so glitch rejection can be shown directly. The short window also lets the bench step through all three switchover rules, the first arming and the factory clear in a few hundred cycles.

// File: rtl/sfg_pkg.sv
package sfg_pkg;

  typedef enum logic {
    RULE_BAT_LEVEL = 1'b0,
    RULE_PF_LEVEL  = 1'b1
  } sw_rule_e;

  // Picks the comparator whose loss moves the supply to the cell.
  function automatic sw_rule_e pick_rule(input logic low_volt, input logic pf_under_bat);
    return (low_volt && pf_under_bat) ? RULE_PF_LEVEL : RULE_BAT_LEVEL;
  endfunction

endpackage

// File: rtl/sfg_rst_sync.sv
module sfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d[0] = 1'b1;
    for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/sfg_flag_filter.sv
module sfg_flag_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int CONFIRM     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic flag_o
);
  localparam int HIST = CONFIRM - 1;

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [HIST-1:0]        hist_q, hist_d;
  logic                   sync_top;
  logic                   agree;
  logic                   flag_q;

  assign sync_top = sync_q[SYNC_STAGES-1];

  always_comb begin
    sync_d[0] = raw_i;
    for (int i = 1; i < SYNC_STAGES; i++) sync_d[i] = sync_q[i-1];
    hist_d[0] = sync_top;
    for (int j = 1; j < HIST; j++) hist_d[j] = hist_q[j-1];
    agree = (hist_q == {HIST{sync_top}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= '0;
    end else begin
      sync_q <= sync_d;
      hist_q <= hist_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (agree) flag_q <= sync_top;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/sfg_bat_latch.sv
module sfg_bat_latch (
  input  logic clk,
  input  logic frst_n,
  input  logic set_i,
  output logic armed_o
);
  logic armed_q;

  always_ff @(posedge clk or negedge frst_n) begin
    if (!frst_n)    armed_q <= 1'b0;
    else if (set_i) armed_q <= 1'b1;
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/sfg_supply_gate.sv
module sfg_supply_gate #(
  parameter int SYNC_STAGES = 2,
  parameter int CONFIRM     = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic factory_rst_n,
  input  logic pf_ok_raw,
  input  logic bat_ok_raw,
  input  logic low_volt,
  input  logic pf_under_bat,
  input  logic acc_req,
  input  logic acc_wr,
  output logic acc_grant,
  output logic wr_grant,
  output logic bat_sel,
  output logic bat_armed
);
  import sfg_pkg::*;

  localparam int NFLAG = 2;
  localparam int IDX_PF  = 0;
  localparam int IDX_BAT = 1;

  logic             rst_core_n;
  logic             frst_core_n;
  logic [NFLAG-1:0] raw_vec;
  logic [NFLAG-1:0] ok_vec;
  logic             pf_ok, bat_ok;
  logic             need_bat;
  sw_rule_e         rule;

  sfg_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk(clk), .arst_n(rst_n), .srst_n(rst_core_n)
  );

  sfg_rst_sync #(.STAGES(RST_STAGES)) u_frst_sync (
    .clk(clk), .arst_n(factory_rst_n), .srst_n(frst_core_n)
  );

  assign raw_vec[IDX_PF]  = pf_ok_raw;
  assign raw_vec[IDX_BAT] = bat_ok_raw;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    sfg_flag_filter #(.SYNC_STAGES(SYNC_STAGES), .CONFIRM(CONFIRM)) u_filt (
      .clk(clk), .rst_n(rst_core_n), .raw_i(raw_vec[g]), .flag_o(ok_vec[g])
    );
  end

  assign pf_ok  = ok_vec[IDX_PF];
  assign bat_ok = ok_vec[IDX_BAT];

  sfg_bat_latch u_latch (
    .clk(clk), .frst_n(frst_core_n), .set_i(pf_ok), .armed_o(bat_armed)
  );

  always_comb begin
    rule     = pick_rule(low_volt, pf_under_bat);
    need_bat = (rule == RULE_PF_LEVEL) ? !pf_ok : !bat_ok;
  end

  assign bat_sel   = bat_armed & need_bat;
  assign acc_grant = acc_req & pf_ok;
  assign wr_grant  = acc_req & acc_wr & pf_ok;
endmodule

// File: rtl/sfg_gate_checker.sv
module sfg_gate_checker (
  input logic clk,
  input logic rst_core_n,
  input logic frst_core_n,
  input logic acc_req,
  input logic acc_wr,
  input logic acc_grant,
  input logic wr_grant,
  input logic bat_sel,
  input logic bat_armed
);
  AST_ARMED_STICKY: assert property (@(posedge clk) disable iff (!frst_core_n)
    bat_armed |=> bat_armed); // R10

  AST_GRANT_ARMS: assert property (@(posedge clk) disable iff (!rst_core_n || !frst_core_n)
    acc_grant |=> bat_armed); // R10

  AST_WR_IN_GRANT: assert property (@(posedge clk) disable iff (!rst_core_n)
    wr_grant |-> (acc_grant && acc_wr)); // R2

  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_core_n)
    acc_grant |-> acc_req); // R2

  AST_SEL_NEEDS_ARM: assert property (@(posedge clk) disable iff (!frst_core_n)
    bat_sel |-> bat_armed); // R9
endmodule

bind sfg_supply_gate sfg_gate_checker u_chk (
  .clk(clk), .rst_core_n(rst_core_n), .frst_core_n(frst_core_n),
  .acc_req(acc_req), .acc_wr(acc_wr), .acc_grant(acc_grant),
  .wr_grant(wr_grant), .bat_sel(bat_sel), .bat_armed(bat_armed)
);

// File: tb/sim_sfg_supply_gate.sv
`timescale 1ns/1ps
module sim_sfg_supply_gate;
  localparam int SYNC = 2;
  localparam int CONF = 2;
  localparam int LAT  = SYNC + CONF;

  logic clk = 1'b0;
  logic rst_n, factory_rst_n, pf_ok_raw, bat_ok_raw, low_volt, pf_under_bat;
  logic acc_req, acc_wr;
  logic acc_grant, wr_grant, bat_sel, bat_armed;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  sfg_supply_gate #(.SYNC_STAGES(SYNC), .CONFIRM(CONF)) u0 (
    .clk(clk), .rst_n(rst_n), .factory_rst_n(factory_rst_n),
    .pf_ok_raw(pf_ok_raw), .bat_ok_raw(bat_ok_raw), .low_volt(low_volt),
    .pf_under_bat(pf_under_bat), .acc_req(acc_req), .acc_wr(acc_wr),
    .acc_grant(acc_grant), .wr_grant(wr_grant), .bat_sel(bat_sel), .bat_armed(bat_armed)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 0; factory_rst_n = 0; pf_ok_raw = 0; bat_ok_raw = 0;
    low_volt = 0; pf_under_bat = 0; acc_req = 1; acc_wr = 1;
    edges(3);
    chk("R1 grant in reset", acc_grant, 1'b0);
    chk("R1 wr in reset", wr_grant, 1'b0);
    rst_n = 1; factory_rst_n = 1;
    edges(8);
    chk("R1 grant after reset", acc_grant, 1'b0);
    chk("R9 unarmed", bat_armed, 1'b0);
    chk("R9 no sel while unarmed", bat_sel, 1'b0);
  endtask

  task automatic t_power_up;
    pf_ok_raw = 1; bat_ok_raw = 1;
    edges(LAT - 1);
    chk("R4 old value one edge early", acc_grant, 1'b0);
    edges(1);
    chk("R4 grant at latency", acc_grant, 1'b1);
    chk("R2 wr grant", wr_grant, 1'b1);
    chk("R10 not yet armed", bat_armed, 1'b0);
    edges(1);
    chk("R10 armed", bat_armed, 1'b1);
    acc_wr = 0; #0.1;
    chk("R2 read no wr", wr_grant, 1'b0);
    chk("R2 read grant", acc_grant, 1'b1);
    acc_req = 0; #0.1;
    chk("R2 no req", acc_grant, 1'b0);
    chk("R6 supply good no sel", bat_sel, 1'b0);
  endtask

  task automatic t_glitch;
    acc_req = 1;
    pf_ok_raw = 0; bat_ok_raw = 0;
    edges(1);
    pf_ok_raw = 1; bat_ok_raw = 1;
    for (int i = 0; i < 8; i++) begin
      edges(1);
      chk("R5 glitch grant", acc_grant, 1'b1);
      chk("R5 glitch sel", bat_sel, 1'b0);
    end
  endtask

  task automatic t_drop;
    acc_req = 1; acc_wr = 1;
    pf_ok_raw = 0;
    edges(LAT - 1);
    chk("R3 write still held", wr_grant, 1'b1);
    edges(1);
    chk("R3 write cut", wr_grant, 1'b0);
    chk("R3 grant cut", acc_grant, 1'b0);
    chk("R6 pf loss ignored in 5V", bat_sel, 1'b0);
    bat_ok_raw = 0;
    edges(LAT);
    chk("R6 battery selected", bat_sel, 1'b1);
    chk("R10 armed after loss", bat_armed, 1'b1);
  endtask

  task automatic t_ord_reset;
    rst_n = 0;
    edges(3);
    rst_n = 1;
    edges(8);
    chk("R10 armed after ordinary reset", bat_armed, 1'b1);
    chk("R1 no grant after reset", acc_grant, 1'b0);
  endtask

  task automatic t_low_volt;
    low_volt = 1; pf_under_bat = 1; #0.1;
    chk("R7 sel pf low", bat_sel, 1'b1);
    bat_ok_raw = 1;
    edges(LAT + 1);
    chk("R7 bat flag ignored", bat_sel, 1'b1);
    pf_ok_raw = 1;
    edges(LAT + 1);
    chk("R7 pf good releases", bat_sel, 1'b0);
    bat_ok_raw = 0;
    edges(LAT + 1);
    chk("R7 bat low ignored", bat_sel, 1'b0);
    pf_under_bat = 0; #0.1;
    chk("R8 strap change", bat_sel, 1'b1);
    bat_ok_raw = 1;
    edges(LAT + 1);
    chk("R8 bat good", bat_sel, 1'b0);
    pf_ok_raw = 0;
    edges(LAT + 1);
    chk("R8 pf loss ignored", bat_sel, 1'b0);
  endtask

  task automatic t_factory;
    bat_ok_raw = 0;
    edges(LAT + 1);
    chk("R8 bat low selects", bat_sel, 1'b1);
    factory_rst_n = 0; #0.1;
    chk("R11 cleared at once", bat_armed, 1'b0);
    edges(2);
    factory_rst_n = 1;
    edges(8);
    chk("R11 stays clear", bat_armed, 1'b0);
    chk("R9 no sel after clear", bat_sel, 1'b0);
    pf_ok_raw = 1;
    edges(LAT + 1);
    chk("R11 rearms on valid supply", bat_armed, 1'b1);
  endtask

  initial begin
    t_reset();
    t_power_up();
    t_glitch();
    t_drop();
    t_ord_reset();
    t_low_volt();
    t_factory();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule